// File: doc/BRIEF.md
# Full-Stall Read-After-Write Interlock

This block decides, every cycle, whether the instruction sitting in the decode stage of a five-stage pipeline may move on. The pipeline has no bypass paths, so an instruction that reads a register must wait until every older instruction that writes that register has left the write-back stage. The block compares both source register indices of the decoding instruction against the destination indices of the execute, memory and write-back stages. It counts a stage only when that stage's write enable is set.

When any live comparison matches, the block holds the program counter and the fetch/decode register. It also tells the decode/execute register to load a no-op in place of the decoding instruction, so an empty slot travels down the pipe while the dependent instruction waits. The logic is purely combinational. The pipeline around it supplies the stage fields and uses the three control outputs as write enables.

A source with index zero never causes a stall, because that register always reads as zero. A per-operand use flag masks out sources that the instruction encoding carries but does not read.

Top module: `raw_interlock`

## Requirements
- R1: The first source stalls the pipe when its use flag is 1, its index is nonzero, and the index equals the destination index of at least one of the execute, memory or write-back stages whose write enable is 1.
- R2: The second source is checked the same way, and a match on either source stalls the pipe.
- R3: A stage whose write enable is 0 never causes a stall, whatever destination index it carries. An injected no-op therefore never matches.
- R4: A source index of zero never causes a stall, even when a stage with write enable 1 names register zero as its destination.
- R5: A source whose use flag is 0 never causes a stall, whatever its index.
- R6: While a stall is in force, the program-counter enable is 0, the fetch/decode enable is 0 and the bubble request is 1.
- R7: With no stall, including straight after reset when every stage is empty, the program-counter enable is 1, the fetch/decode enable is 1 and the bubble request is 0.
- R8: An instruction that reads the result of the instruction directly ahead of it waits exactly 3 cycles in decode. A gap of one independent instruction costs 2 cycles, and a gap of two costs 1 cycle.
- R9: A pipeline driven by this block produces, for dependent chains of add, sub, or and and, the same register results as sequential execution, with the last write-back at edge N+4+S (N instructions, S stall cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | REG_AW | First source register index of the decoding instruction |
| src_a_use | input | 1 | 1 when the decoding instruction reads the first source |
| src_b_idx | input | REG_AW | Second source register index of the decoding instruction |
| src_b_use | input | 1 | 1 when the decoding instruction reads the second source |
| ex_dst_idx | input | REG_AW | Destination index held in the decode/execute register |
| ex_dst_we | input | 1 | Register write enable of the execute-stage instruction |
| mem_dst_idx | input | REG_AW | Destination index held in the execute/memory register |
| mem_dst_we | input | 1 | Register write enable of the memory-stage instruction |
| wb_dst_idx | input | REG_AW | Destination index held in the memory/write-back register |
| wb_dst_we | input | 1 | Register write enable of the write-back-stage instruction |
| pc_we | output | 1 | Program-counter update enable |
| ifid_we | output | 1 | Fetch/decode register load enable |
| idex_bubble | output | 1 | Load a no-op into the decode/execute register |

## Verification
The assertions run on every evaluation. They check that a masked, zero-index or unwritten-stage operand never raises a match (R3, R4, R5), and that the three outputs move together as a freeze or as free flow in line with the two per-operand match results (R6, R7). The match condition itself (R1, R2) is checked by a full sweep of a 2-bit-index instance. Stall lengths over instruction distance and the correctness of results through a real pipe (R8, R9) only show up in the bench's pipeline programs, which count stall cycles and the edge of the last write-back.

// File: rtl/hz_pkg.sv
package hz_pkg;

   // Number of downstream stages that can hold a pending register write.
   localparam int unsigned HZ_STAGES = 3;

   // Slot order inside the destination arrays.
   typedef enum int unsigned {
      HZ_EX  = 0,
      HZ_MEM = 1,
      HZ_WB  = 2
   } hz_stage_e;

endpackage

// File: rtl/hz_src_match.sv
// One source operand compared against every downstream destination.
module hz_src_match #(
   parameter int unsigned AW         = 5,
   parameter int unsigned NSTG       = 3,
   parameter bit          ZERO_FIXED = 1'b1
) (
   input  logic [AW-1:0] src_idx,
   input  logic          src_use,
   input  logic [AW-1:0] dst_idx [NSTG],
   input  logic [NSTG-1:0] dst_we,
   output logic          hit
);

   if (AW < 1) begin : g_bad_aw
      $error("hz_src_match: AW must be at least 1");
   end
   if (NSTG < 1) begin : g_bad_nstg
      $error("hz_src_match: NSTG must be at least 1");
   end

   logic [NSTG-1:0] stage_hit;
   logic            live;

   for (genvar s = 0; s < NSTG; s++) begin : g_stage
      assign stage_hit[s] = dst_we[s] && (dst_idx[s] == src_idx);
   end

   // Variant choice: a hard-wired zero register can never be a hazard.
   if (ZERO_FIXED) begin : g_zero_fixed
      assign live = src_use && (src_idx != '0);
   end else begin : g_zero_plain
      assign live = src_use;
   end

   assign hit = live && (|stage_hit);

endmodule

// File: rtl/hz_stall_ctrl.sv
// Turns per-source match flags into freeze/bubble controls.
module hz_stall_ctrl #(
   parameter int unsigned NSRC = 2
) (
   input  logic [NSRC-1:0] src_hit,
   output logic            pc_we,
   output logic            ifid_we,
   output logic            idex_bubble
);

   if (NSRC < 1) begin : g_bad_nsrc
      $error("hz_stall_ctrl: NSRC must be at least 1");
   end

   logic stall;

   always_comb begin
      stall       = |src_hit;
      pc_we       = !stall;
      ifid_we     = !stall;
      idex_bubble = stall;
   end

endmodule

// File: rtl/raw_interlock.sv
module raw_interlock
   import hz_pkg::*;
#(
   parameter int unsigned REG_AW         = 5,
   parameter bit          ZERO_REG_FIXED = 1'b1
) (
   input  logic [REG_AW-1:0] src_a_idx,
   input  logic              src_a_use,
   input  logic [REG_AW-1:0] src_b_idx,
   input  logic              src_b_use,
   input  logic [REG_AW-1:0] ex_dst_idx,
   input  logic              ex_dst_we,
   input  logic [REG_AW-1:0] mem_dst_idx,
   input  logic              mem_dst_we,
   input  logic [REG_AW-1:0] wb_dst_idx,
   input  logic              wb_dst_we,
   output logic              pc_we,
   output logic              ifid_we,
   output logic              idex_bubble
);

   localparam int unsigned NSRC = 2;

   if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
      $error("raw_interlock: REG_AW must lie in 1..8");
   end

   logic [REG_AW-1:0]    dst_idx [HZ_STAGES];
   logic [HZ_STAGES-1:0] dst_we;
   logic                 hit_a;
   logic                 hit_b;

   assign dst_idx[HZ_EX]  = ex_dst_idx;
   assign dst_idx[HZ_MEM] = mem_dst_idx;
   assign dst_idx[HZ_WB]  = wb_dst_idx;
   assign dst_we[HZ_EX]   = ex_dst_we;
   assign dst_we[HZ_MEM]  = mem_dst_we;
   assign dst_we[HZ_WB]   = wb_dst_we;

   hz_src_match #(
      .AW(REG_AW), .NSTG(HZ_STAGES), .ZERO_FIXED(ZERO_REG_FIXED)
   ) u_cmp_a (
      .src_idx(src_a_idx), .src_use(src_a_use),
      .dst_idx(dst_idx), .dst_we(dst_we), .hit(hit_a)
   );

   hz_src_match #(
      .AW(REG_AW), .NSTG(HZ_STAGES), .ZERO_FIXED(ZERO_REG_FIXED)
   ) u_cmp_b (
      .src_idx(src_b_idx), .src_use(src_b_use),
      .dst_idx(dst_idx), .dst_we(dst_we), .hit(hit_b)
   );

   hz_stall_ctrl #(.NSRC(NSRC)) u_ctl (
      .src_hit({hit_b, hit_a}),
      .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble)
   );

   // Checks across the comparator and control sub-blocks.
   always_comb begin
      if (!src_a_use) begin
         p_unused_a_r5: assert (!hit_a);
      end
      if (!src_b_use) begin
         p_unused_b_r5: assert (!hit_b);
      end
      if (ZERO_REG_FIXED && src_a_idx == '0) begin
         p_zero_a_r4: assert (!hit_a);
      end
      if (ZERO_REG_FIXED && src_b_idx == '0) begin
         p_zero_b_r4: assert (!hit_b);
      end
      if (dst_we == '0) begin
         p_no_writer_r3: assert (!hit_a && !hit_b);
      end
      if (hit_a || hit_b) begin
         p_freeze_r6: assert (!pc_we && !ifid_we && idex_bubble);
      end else begin
         p_flow_r7: assert (pc_we && ifid_we && !idex_bubble);
      end
   end

endmodule

// File: tb/raw_interlock_tb.sv
`timescale 1ns/1ps
module raw_interlock_tb;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // ---------------- sweep instance: 2-bit indices ----------------
   logic [1:0] s_a, s_b, s_ed, s_md, s_wd;
   logic       s_ua, s_ub, s_ew, s_mw, s_ww;
   logic       s_pc, s_ifid, s_bub;

   raw_interlock #(.REG_AW(2)) u_sweep (
      .src_a_idx(s_a), .src_a_use(s_ua), .src_b_idx(s_b), .src_b_use(s_ub),
      .ex_dst_idx(s_ed), .ex_dst_we(s_ew), .mem_dst_idx(s_md), .mem_dst_we(s_mw),
      .wb_dst_idx(s_wd), .wb_dst_we(s_ww),
      .pc_we(s_pc), .ifid_we(s_ifid), .idex_bubble(s_bub)
   );

   function automatic bit src_exp(logic [1:0] i, logic u, logic [1:0] ed, logic ew,
                                  logic [1:0] md, logic mw, logic [1:0] wd, logic ww);
      return u && (i != 2'd0) && ((ew && i == ed) || (mw && i == md) || (ww && i == wd));
   endfunction

   task automatic apply(int v);
      s_a  = v[1:0];   s_ua = v[2];
      s_b  = v[4:3];   s_ub = v[5];
      s_ed = v[7:6];   s_ew = v[8];
      s_md = v[10:9];  s_mw = v[11];
      s_wd = v[13:12]; s_ww = v[14];
      #1;
   endtask

   // Check the three outputs against an expected stall value.
   task automatic chk_ctl(bit exp_stall, string req);
      bit ok;
      ok = (s_pc == !exp_stall) && (s_ifid == !exp_stall) && (s_bub == exp_stall);
      chk(ok, req, "pc_we/ifid_we/bubble", {s_pc, s_ifid, s_bub},
          {!exp_stall, !exp_stall, exp_stall});
   endtask

   // ---------------- pipeline instance: 8 registers ----------------
   typedef enum logic [2:0] {I_NOP, I_ADD, I_SUB, I_AND, I_OR, I_LI} iop_e;
   typedef struct packed {
      iop_e        op;
      logic [2:0]  rd;
      logic [2:0]  ra;
      logic [2:0]  rb;
      logic [15:0] imm;
   } ins_t;

   localparam ins_t NOP = '{op: I_NOP, rd: 3'd0, ra: 3'd0, rb: 3'd0, imm: 16'd0};

   function automatic ins_t mk(iop_e op, int rd, int ra, int rb, int imm);
      ins_t r;
      r.op = op; r.rd = rd[2:0]; r.ra = ra[2:0]; r.rb = rb[2:0]; r.imm = imm[15:0];
      return r;
   endfunction

   function automatic bit reads(iop_e op);
      return op == I_ADD || op == I_SUB || op == I_AND || op == I_OR;
   endfunction

   function automatic logic [15:0] alu(ins_t i, logic [15:0] x, logic [15:0] y);
      case (i.op)
         I_ADD:   return x + y;
         I_SUB:   return x - y;
         I_AND:   return x & y;
         I_OR:    return x | y;
         I_LI:    return i.imm;
         default: return 16'd0;
      endcase
   endfunction

   ins_t        imem [8];
   int          nprog = 0;
   logic        rst = 1'b1;
   int          pc;
   logic [15:0] rf [8];

   ins_t ifid_i;  logic ifid_v; int ifid_seq;
   ins_t idex_i;  logic idex_v; int idex_seq; logic [15:0] idex_va, idex_vb;
   ins_t exm_i;   logic exm_v;  int exm_seq;  logic [15:0] exm_res;
   ins_t mwb_i;   logic mwb_v;  int mwb_seq;  logic [15:0] mwb_res;
   int   edge_cnt, stall_cnt, done_edge;

   logic p_pc, p_ifid, p_bub;

   raw_interlock #(.REG_AW(3)) u_dut (
      .src_a_idx(ifid_i.ra), .src_a_use(ifid_v && reads(ifid_i.op)),
      .src_b_idx(ifid_i.rb), .src_b_use(ifid_v && reads(ifid_i.op)),
      .ex_dst_idx(idex_i.rd),  .ex_dst_we(idex_v && idex_i.op != I_NOP),
      .mem_dst_idx(exm_i.rd),  .mem_dst_we(exm_v && exm_i.op != I_NOP),
      .wb_dst_idx(mwb_i.rd),   .wb_dst_we(mwb_v && mwb_i.op != I_NOP),
      .pc_we(p_pc), .ifid_we(p_ifid), .idex_bubble(p_bub)
   );

   always @(posedge clk) begin
      if (rst) begin
         pc <= 0;
         ifid_i <= NOP; ifid_v <= 1'b0; ifid_seq <= 0;
         idex_i <= NOP; idex_v <= 1'b0; idex_seq <= 0; idex_va <= '0; idex_vb <= '0;
         exm_i  <= NOP; exm_v  <= 1'b0; exm_seq  <= 0; exm_res <= '0;
         mwb_i  <= NOP; mwb_v  <= 1'b0; mwb_seq  <= 0; mwb_res <= '0;
         edge_cnt <= 0; stall_cnt <= 0; done_edge <= -1;
         for (int k = 0; k < 8; k++) rf[k] <= 16'(10 * k);
      end else begin
         edge_cnt <= edge_cnt + 1;
         if (!p_pc) stall_cnt <= stall_cnt + 1;
         if (mwb_v && mwb_i.op != I_NOP && mwb_i.rd != 3'd0) rf[mwb_i.rd] <= mwb_res;
         if (mwb_v && mwb_seq == nprog - 1) done_edge <= edge_cnt + 1;
         mwb_i <= exm_i; mwb_v <= exm_v; mwb_seq <= exm_seq; mwb_res <= exm_res;
         exm_i <= idex_i; exm_v <= idex_v; exm_seq <= idex_seq;
         exm_res <= alu(idex_i, idex_va, idex_vb);
         if (p_bub) begin
            idex_i <= NOP; idex_v <= 1'b0;
         end else begin
            idex_i <= ifid_i; idex_v <= ifid_v; idex_seq <= ifid_seq;
            idex_va <= rf[ifid_i.ra]; idex_vb <= rf[ifid_i.rb];
         end
         if (p_ifid) begin
            if (pc < nprog) begin
               ifid_i <= imem[pc]; ifid_v <= 1'b1; ifid_seq <= pc;
            end else begin
               ifid_i <= NOP; ifid_v <= 1'b0;
            end
         end
         if (p_pc && pc < nprog) pc <= pc + 1;
      end
   end

   task automatic run_prog(string req, int exp_stalls);
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(p_pc && p_ifid && !p_bub, "R7", "outputs after reset", {p_pc, p_ifid, p_bub}, 3'b110);
      rst = 1'b0;
      repeat (40) @(posedge clk);
      @(negedge clk);
      chk(stall_cnt == exp_stalls, req, "stall cycles", stall_cnt, exp_stalls);
      chk(done_edge == nprog + 4 + exp_stalls, "R9", "last write-back edge",
          done_edge, nprog + 4 + exp_stalls);
   endtask

   // Watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         finished = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      // ---- directed combinational cases ----
      // R7: all stages idle
      apply(0);                                   chk_ctl(1'b0, "R7");
      // R1: a=1 used, EX writes r1
      apply(1 | (1<<2) | (1<<6) | (1<<8));        chk_ctl(1'b1, "R1");
      // R1: a=3 used, only WB writes r3
      apply(3 | (1<<2) | (3<<12) | (1<<14));      chk_ctl(1'b1, "R1");
      // R2: b=2 used, MEM writes r2, a unused
      apply((2<<3) | (1<<5) | (2<<9) | (1<<11));  chk_ctl(1'b1, "R2");
      // R3: all destinations match a=2 but no write enables
      apply(2 | (1<<2) | (2<<6) | (2<<9) | (2<<12)); chk_ctl(1'b0, "R3");
      // R4: a=0 used, every stage writes r0
      apply((1<<2) | (1<<8) | (1<<11) | (1<<14)); chk_ctl(1'b0, "R4");
      // R5: a=1 and b=1 matching EX but both unused
      apply(1 | (1<<3) | (1<<6) | (1<<8));        chk_ctl(1'b0, "R5");

      // ---- full sweep: R1 R2 R3 R4 R5 R6 R7 ----
      for (int v = 0; v < 32768; v++) begin
         bit e;
         apply(v);
         e = src_exp(s_a, s_ua, s_ed, s_ew, s_md, s_mw, s_wd, s_ww) ||
             src_exp(s_b, s_ub, s_ed, s_ew, s_md, s_mw, s_wd, s_ww);
         chk_ctl(e, e ? "R6" : "R7");
      end

      // ---- program A: distance-1 then distance-2 dependences (R8) ----
      imem[0] = mk(I_ADD, 3, 1, 2, 0);
      imem[1] = mk(I_SUB, 5, 3, 4, 0);
      imem[2] = mk(I_OR,  6, 3, 4, 0);
      imem[3] = mk(I_AND, 7, 3, 5, 0);
      nprog = 4;
      run_prog("R8", 5);
      chk(rf[3] == 16'd30,     "R9", "A r3", rf[3], 30);
      chk(rf[5] == 16'hFFF6,   "R9", "A r5", rf[5], 16'hFFF6);
      chk(rf[6] == 16'd62,     "R9", "A r6", rf[6], 62);
      chk(rf[7] == 16'd22,     "R9", "A r7", rf[7], 22);

      // ---- program B: zero register, unused source, distance 3 ----
      imem[0] = mk(I_ADD, 1, 2, 3, 0);
      imem[1] = mk(I_ADD, 4, 5, 6, 0);
      imem[2] = mk(I_ADD, 0, 1, 1, 0);
      imem[3] = mk(I_ADD, 6, 0, 0, 0);
      imem[4] = mk(I_SUB, 2, 1, 4, 0);
      imem[5] = mk(I_LI,  3, 2, 2, 16'h55);
      nprog = 6;
      run_prog("R4", 2);
      chk(rf[1] == 16'd50,     "R9", "B r1", rf[1], 50);
      chk(rf[4] == 16'd110,    "R9", "B r4", rf[4], 110);
      chk(rf[6] == 16'd0,      "R4", "B r6", rf[6], 0);
      chk(rf[2] == 16'hFFC4,   "R9", "B r2", rf[2], 16'hFFC4);
      chk(rf[3] == 16'h55,     "R5", "B r3", rf[3], 16'h55);

      // ---- program C: back-to-back dependence, 3 stalls (R8) ----
      imem[0] = mk(I_ADD, 1, 2, 3, 0);
      imem[1] = mk(I_SUB, 4, 1, 2, 0);
      nprog = 2;
      run_prog("R8", 3);
      chk(rf[4] == 16'd30,     "R8", "C r4", rf[4], 30);

      // ---- program D: distance 3 alone costs 1 stall (R8) ----
      imem[0] = mk(I_ADD, 1, 2, 3, 0);
      imem[1] = mk(I_ADD, 5, 2, 2, 0);
      imem[2] = mk(I_ADD, 6, 3, 3, 0);
      imem[3] = mk(I_OR,  7, 1, 0, 0);
      nprog = 4;
      run_prog("R8", 1);
      chk(rf[7] == 16'd50,     "R9", "D r7", rf[7], 50);

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule